// File: doc/BRIEF.md
# Overvoltage Fault Reaction Controller

This block decides what the device does once an overvoltage event has been seen on its regulated supply rail. It takes a synchronized one-cycle overvoltage event and the present device mode. It also takes a software-writable enable that arms a reset reaction, a configuration strap and a programmable delay. From these it drives a sticky status flag and requests for either a timed restart or a latched fail-safe state. It also drives a fault-output activation and a one-cycle pulse that sends the device back to normal operation once the restart delay has run out.

Sensing, noise filtering and the device-wide mode sequencer sit outside. The block only reports the reaction it wants. The mode sequencer acts on the restart and fail-safe requests and on the return-to-normal pulse. The strap picks the reaction. With the strap high, an armed event gives a bounded restart, after which the device resumes normally even if the rail is still high. With the strap low, an armed event gives a fail-safe state that only a reset can leave.

Top module: `ovr_fault_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, ov_sts, rst_en, restart_req, failsafe_req, fault_act and resume_normal are all 0.
- R2: The mode input is decoded as 0 init, 1 normal, 2 stop, 3 sleep, 4 restart, 5 fail-safe. An ov_evt that arrives while the mode is 3 or higher has no effect on any output.
- R3: An ov_evt that arrives while the mode is 0, 1 or 2 sets ov_sts from the next cycle, whatever the value of rst_en or strap_cfg. ov_sts then holds until a sts_w1c pulse clears it. When set and clear arrive in the same cycle, the set wins.
- R4: When rst_en is 0, a detected event changes ov_sts only. restart_req, failsafe_req and fault_act stay 0.
- R5: A detected event with rst_en=1 and strap_cfg=1 raises restart_req and fault_act from the next cycle. Both stay high for exactly delay_cfg+1 cycles.
- R6: rst_en is loaded from en_wdata on an en_wr pulse. rst_en is cleared by hardware when the restart reaction is taken, and this clear wins over a software write in the same cycle.
- R7: resume_normal is high for exactly one cycle: the first cycle after restart_req falls. This happens even if ov_evt is still asserted.
- R8: A detected event with rst_en=1 and strap_cfg=0 raises failsafe_req and fault_act from the next cycle. Both then hold until reset.
- R9: While a restart or fail-safe reaction is active, a further event starts no new reaction. restart_req and failsafe_req are never high together.
- R10: The delay is taken from delay_cfg in the cycle the restart is entered. Changing delay_cfg during a restart does not change its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ov_evt | input | 1 | Synchronized overvoltage event |
| mode_i | input | 3 | Present device mode (encoding in R2) |
| strap_cfg | input | 1 | 1 selects timed restart, 0 selects latched fail-safe |
| delay_cfg | input | DLY_W | Restart delay in cycles (restart lasts delay_cfg+1 cycles) |
| en_wr | input | 1 | Write strobe for the reaction enable |
| en_wdata | input | 1 | Value written to the reaction enable |
| sts_w1c | input | 1 | Write-one-to-clear strobe for ov_sts |
| ov_sts | output | 1 | Sticky overvoltage status |
| rst_en | output | 1 | Reaction enable readback |
| restart_req | output | 1 | Restart mode request |
| failsafe_req | output | 1 | Fail-safe mode request |
| fault_act | output | 1 | Fault output activation |
| resume_normal | output | 1 | One-cycle return-to-normal pulse |

## Verification
The properties assume that ov_evt is already synchronous to clk and that the register strobes are single-cycle, synchronous requests. They also assume that mode_i only ever carries codes 0 to 5. The stimulus drives every input at the falling edge and keeps mode_i inside the defined codes. It still holds ov_evt high for many cycles on purpose, so that a rail that stays high is covered. The length property latches delay_cfg at restart entry, so the bench changes delay_cfg freely during a restart without breaking it.

// File: rtl/ovr_pkg.sv
package ovr_pkg;

   // device mode codes as driven by the mode sequencer
   typedef enum logic [2:0] {
      MD_INIT     = 3'd0,
      MD_NORMAL   = 3'd1,
      MD_STOP     = 3'd2,
      MD_SLEEP    = 3'd3,
      MD_RESTART  = 3'd4,
      MD_FAILSAFE = 3'd5
   } dev_mode_e;

   // reaction state of this block
   typedef enum logic [1:0] {
      RX_IDLE    = 2'd0,
      RX_RESTART = 2'd1,
      RX_LATCH   = 2'd2
   } react_st_e;

   // detection window: only the active supply modes watch the rail
   function automatic logic ov_mode_ok(input logic [2:0] m);
      return (m == MD_INIT) || (m == MD_NORMAL) || (m == MD_STOP);
   endfunction

endpackage

// File: rtl/ovr_status_reg.sv
module ovr_status_reg #(
   parameter bit SET_OVER_CLR = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic en_wr,
   input  logic en_wdata,
   input  logic en_hwclr,
   output logic sts_o,
   output logic en_o
);

   logic sts_q;
   logic en_q;

   // sticky status: the priority between set and clear is a build option
   generate
      if (SET_OVER_CLR) begin : g_set_wins
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      sts_q <= 1'b0;
            else if (set_i)  sts_q <= 1'b1;
            else if (clr_i)  sts_q <= 1'b0;
         end
      end else begin : g_clr_wins
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      sts_q <= 1'b0;
            else if (clr_i)  sts_q <= 1'b0;
            else if (set_i)  sts_q <= 1'b1;
         end
      end
   endgenerate

   // reaction enable: hardware self-clear beats a software write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         en_q <= 1'b0;
      else if (en_hwclr)  en_q <= 1'b0;
      else if (en_wr)     en_q <= en_wdata;
   end

   assign sts_o = sts_q;
   assign en_o  = en_q;

endmodule

// File: rtl/ovr_delay_cnt.sv
module ovr_delay_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         run,
   output logic         done
);

   localparam logic [W-1:0] ZERO = '0;
   localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt_q <= ZERO;
      else if (load)                  cnt_q <= load_val;
      else if (run && cnt_q != ZERO)  cnt_q <= cnt_q - ONE;
   end

   assign done = run && (cnt_q == ZERO);

endmodule

// File: rtl/ovr_react_fsm.sv
module ovr_react_fsm
   import ovr_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic detect,
   input  logic armed,
   input  logic strap,
   input  logic dly_done,
   output logic take_restart,
   output logic dly_run,
   output logic restart_o,
   output logic latch_o,
   output logic resume_o
);

   react_st_e st_q, st_d;
   logic      resume_q;
   logic      take_latch;

   // a reaction starts only from idle, so a busy block ignores new events
   assign take_restart = (st_q == RX_IDLE) && detect && armed && strap;
   assign take_latch   = (st_q == RX_IDLE) && detect && armed && !strap;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         RX_IDLE: begin
            if (take_restart)     st_d = RX_RESTART;
            else if (take_latch)  st_d = RX_LATCH;
         end
         RX_RESTART: begin
            if (dly_done)         st_d = RX_IDLE;
         end
         RX_LATCH:                st_d = RX_LATCH;
         default:                 st_d = RX_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= RX_IDLE;
         resume_q <= 1'b0;
      end else begin
         st_q     <= st_d;
         resume_q <= (st_q == RX_RESTART) && dly_done;
      end
   end

   assign dly_run   = (st_q == RX_RESTART);
   assign restart_o = (st_q == RX_RESTART);
   assign latch_o   = (st_q == RX_LATCH);
   assign resume_o  = resume_q;

endmodule

// File: rtl/ovr_fault_ctrl.sv
module ovr_fault_ctrl #(
   parameter int DLY_W        = 8,
   parameter bit SET_OVER_CLR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ov_evt,
   input  logic [2:0]       mode_i,
   input  logic             strap_cfg,
   input  logic [DLY_W-1:0] delay_cfg,
   input  logic             en_wr,
   input  logic             en_wdata,
   input  logic             sts_w1c,
   output logic             ov_sts,
   output logic             rst_en,
   output logic             restart_req,
   output logic             failsafe_req,
   output logic             fault_act,
   output logic             resume_normal
);

   localparam int MAX_DLY_W = 24;

   generate
      if (DLY_W < 1 || DLY_W > MAX_DLY_W) begin : g_bad_width
         $error("ovr_fault_ctrl: DLY_W out of range");
      end
   endgenerate

   logic detect;
   logic take_restart;
   logic dly_run;
   logic dly_done;
   logic en_q;

   assign detect = ov_evt && ovr_pkg::ov_mode_ok(mode_i);

   ovr_status_reg #(
      .SET_OVER_CLR (SET_OVER_CLR)
   ) u_sts (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (detect),
      .clr_i    (sts_w1c),
      .en_wr    (en_wr),
      .en_wdata (en_wdata),
      .en_hwclr (take_restart),
      .sts_o    (ov_sts),
      .en_o     (en_q)
   );

   ovr_react_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .detect       (detect),
      .armed        (en_q),
      .strap        (strap_cfg),
      .dly_done     (dly_done),
      .take_restart (take_restart),
      .dly_run      (dly_run),
      .restart_o    (restart_req),
      .latch_o      (failsafe_req),
      .resume_o     (resume_normal)
   );

   ovr_delay_cnt #(
      .W (DLY_W)
   ) u_dly (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (take_restart),
      .load_val (delay_cfg),
      .run      (dly_run),
      .done     (dly_done)
   );

   assign rst_en    = en_q;
   assign fault_act = restart_req || failsafe_req;

endmodule

// File: rtl/ovr_fault_ctrl_chk.sv
module ovr_fault_ctrl_chk #(
   parameter int DLY_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ov_evt,
   input logic [2:0]       mode_i,
   input logic             strap_cfg,
   input logic [DLY_W-1:0] delay_cfg,
   input logic             en_wr,
   input logic             en_wdata,
   input logic             sts_w1c,
   input logic             ov_sts,
   input logic             rst_en,
   input logic             restart_req,
   input logic             failsafe_req,
   input logic             fault_act,
   input logic             resume_normal
);

   logic             mode_ok;
   logic [DLY_W:0]   run_len;
   logic [DLY_W-1:0] lat_dly;

   assign mode_ok = ovr_pkg::ov_mode_ok(mode_i);

   // window counter for the restart length instead of a deep $past
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_len <= '0;
         lat_dly <= '0;
      end else begin
         run_len <= restart_req ? run_len + 1'b1 : '0;
         if (!restart_req) lat_dly <= delay_cfg;
      end
   end

   // R2
   ign_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ov_evt && !mode_ok && !ov_sts) |=> !ov_sts);

   // R3
   sts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ov_evt && mode_ok) |=> ov_sts);

   // R4
   disarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ov_evt && !rst_en && !restart_req && !failsafe_req) |=> (!restart_req && !failsafe_req));

   // R5
   rst_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(restart_req) |-> fault_act);

   // R5 R10
   rst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(restart_req) |-> (run_len == {1'b0, lat_dly} + 1'b1));

   // R6
   en_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(restart_req) |-> !rst_en);

   // R7
   resume_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(restart_req) |-> resume_normal);

   // R7
   resume_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resume_normal |=> !resume_normal);

   // R8
   fs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      failsafe_req |=> (failsafe_req && fault_act));

   // R9
   excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(restart_req && failsafe_req));

   // R9
   no_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart_req |=> !failsafe_req);

endmodule

bind ovr_fault_ctrl ovr_fault_ctrl_chk #(.DLY_W(DLY_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .ov_evt        (ov_evt),
   .mode_i        (mode_i),
   .strap_cfg     (strap_cfg),
   .delay_cfg     (delay_cfg),
   .en_wr         (en_wr),
   .en_wdata      (en_wdata),
   .sts_w1c       (sts_w1c),
   .ov_sts        (ov_sts),
   .rst_en        (rst_en),
   .restart_req   (restart_req),
   .failsafe_req  (failsafe_req),
   .fault_act     (fault_act),
   .resume_normal (resume_normal)
);

// File: tb/ovr_fault_ctrl_test.sv
module ovr_fault_ctrl_test;

   localparam int CLK_PERIOD = 10;
   localparam int DW         = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ov_evt = 1'b0;
   logic [2:0]    mode_i = 3'd1;
   logic          strap_cfg = 1'b1;
   logic [DW-1:0] delay_cfg = '0;
   logic          en_wr = 1'b0;
   logic          en_wdata = 1'b0;
   logic          sts_w1c = 1'b0;
   logic          ov_sts, rst_en, restart_req, failsafe_req, fault_act, resume_normal;

   ovr_fault_ctrl #(.DLY_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .ov_evt(ov_evt), .mode_i(mode_i),
      .strap_cfg(strap_cfg), .delay_cfg(delay_cfg), .en_wr(en_wr),
      .en_wdata(en_wdata), .sts_w1c(sts_w1c), .ov_sts(ov_sts),
      .rst_en(rst_en), .restart_req(restart_req), .failsafe_req(failsafe_req),
      .fault_act(fault_act), .resume_normal(resume_normal)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int    errors = 0;
   int    checks = 0;
   bit    cmp_on = 1'b0;
   bit    done = 1'b0;
   string cur_req = "R1";

   // behavioural reference: 0 idle, 1 restarting, 2 latched
   int m_sts, m_en, m_state, m_cnt, m_resume;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_sts = 0; m_en = 0; m_state = 0; m_cnt = 0; m_resume = 0;
      end else begin
         int det, trig, n_state, n_cnt;
         det = (ov_evt && mode_i <= 3'd2) ? 1 : 0;
         trig = (det == 1 && m_en == 1 && m_state == 0) ? 1 : 0;
         m_resume = (m_state == 1 && m_cnt == 0) ? 1 : 0;
         n_state = m_state;
         n_cnt = m_cnt;
         if (m_state == 0 && trig == 1) begin
            if (strap_cfg) begin n_state = 1; n_cnt = int'(delay_cfg); end
            else n_state = 2;
         end else if (m_state == 1) begin
            if (m_cnt == 0) n_state = 0;
            else n_cnt = m_cnt - 1;
         end
         if (det == 1) m_sts = 1;
         else if (sts_w1c) m_sts = 0;
         if (trig == 1 && strap_cfg) m_en = 0;
         else if (en_wr) m_en = en_wdata ? 1 : 0;
         m_state = n_state;
         m_cnt = n_cnt;
      end
   end

   task automatic chk(input string req, input string what, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on && rst_n) begin
         chk(cur_req, "ov_sts", int'(ov_sts), m_sts);
         chk(cur_req, "rst_en", int'(rst_en), m_en);
         chk(cur_req, "restart_req", int'(restart_req), (m_state == 1) ? 1 : 0);
         chk(cur_req, "failsafe_req", int'(failsafe_req), (m_state == 2) ? 1 : 0);
         chk(cur_req, "fault_act", int'(fault_act), (m_state != 0) ? 1 : 0);
         chk(cur_req, "resume_normal", int'(resume_normal), m_resume);
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_en(input logic v);
      en_wr = 1'b1; en_wdata = v;
      step(1);
      en_wr = 1'b0; en_wdata = 1'b0;
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog run did not finish");
         done = 1'b1;
         summary();
      end
   end

   initial begin
      int w;
      // R1 reset state
      step(2);
      chk("R1", "outputs in reset",
          int'({ov_sts, rst_en, restart_req, failsafe_req, fault_act, resume_normal}), 0);
      rst_n = 1'b1;
      step(1);
      chk("R1", "outputs after reset",
          int'({ov_sts, rst_en, restart_req, failsafe_req, fault_act, resume_normal}), 0);
      cmp_on = 1'b1;

      // R2 events in sleep, restart and fail-safe modes are ignored
      cur_req = "R2";
      write_en(1'b1);
      strap_cfg = 1'b1;
      for (int m = 3; m <= 5; m++) begin
         mode_i = 3'(m);
         ov_evt = 1'b1; step(1); ov_evt = 1'b0; step(2);
         chk("R2", "no status in ignored mode", int'(ov_sts), 0);
         chk("R2", "no reaction in ignored mode", int'(fault_act), 0);
      end

      // R4 disarmed: status only
      cur_req = "R4";
      write_en(1'b0);
      mode_i = 3'd1;
      ov_evt = 1'b1; step(1); ov_evt = 1'b0; step(3);
      chk("R4", "status set while disarmed", int'(ov_sts), 1);
      chk("R4", "no request while disarmed", int'(restart_req | failsafe_req), 0);

      // R3 write-one-to-clear, and set beats clear
      cur_req = "R3";
      sts_w1c = 1'b1; step(1); sts_w1c = 1'b0;
      chk("R3", "cleared by w1c", int'(ov_sts), 0);
      mode_i = 3'd2;
      ov_evt = 1'b1; sts_w1c = 1'b1; step(1); ov_evt = 1'b0; sts_w1c = 1'b0;
      chk("R3", "set wins over clear", int'(ov_sts), 1);
      step(3);
      chk("R3", "status sticky", int'(ov_sts), 1);
      sts_w1c = 1'b1; step(1); sts_w1c = 1'b0;
      mode_i = 3'd0;
      ov_evt = 1'b1; step(1); ov_evt = 1'b0;
      chk("R3", "set in init mode", int'(ov_sts), 1);

      // R5 R6 R7 R10 restart with rail held high and delay changed mid-run
      cur_req = "R5";
      mode_i = 3'd1;
      delay_cfg = 8'd3;
      write_en(1'b1);
      ov_evt = 1'b1; en_wr = 1'b1; en_wdata = 1'b1;
      step(1);
      en_wr = 1'b0; en_wdata = 1'b0;
      chk("R6", "hw clear beats write", int'(rst_en), 0);
      delay_cfg = 8'd50;
      cur_req = "R10";
      w = 0;
      while (restart_req && w < 200) begin w++; step(1); end
      chk("R5", "restart width", w, 4);
      chk("R10", "width kept despite delay change", w, 4);
      chk("R7", "resume pulse with rail high", int'(resume_normal), 1);
      cur_req = "R7";
      step(1);
      chk("R7", "resume is one cycle", int'(resume_normal), 0);
      chk("R7", "stays idle after resume", int'(restart_req), 0);
      ov_evt = 1'b0;
      step(2);

      // R5 zero delay gives a one-cycle restart
      cur_req = "R5";
      delay_cfg = 8'd0;
      write_en(1'b1);
      ov_evt = 1'b1; step(1); ov_evt = 1'b0;
      w = 0;
      while (restart_req && w < 200) begin w++; step(1); end
      chk("R5", "zero delay width", w, 1);

      // R9 events during a restart start nothing new
      cur_req = "R9";
      delay_cfg = 8'd6;
      write_en(1'b1);
      ov_evt = 1'b1; step(1); ov_evt = 1'b0;
      strap_cfg = 1'b0;
      write_en(1'b1);
      ov_evt = 1'b1; step(1); ov_evt = 1'b0;
      chk("R9", "no fail-safe during restart", int'(failsafe_req), 0);
      write_en(1'b0);
      strap_cfg = 1'b1;
      step(10);
      chk("R9", "back to idle", int'(fault_act), 0);

      // R8 latched fail-safe
      cur_req = "R8";
      strap_cfg = 1'b0;
      write_en(1'b1);
      ov_evt = 1'b1; step(1); ov_evt = 1'b0;
      chk("R8", "fail-safe raised", int'(failsafe_req), 1);
      step(20);
      chk("R8", "fail-safe held", int'(failsafe_req & fault_act), 1);
      cur_req = "R9";
      strap_cfg = 1'b1;
      ov_evt = 1'b1; step(2); ov_evt = 1'b0;
      chk("R9", "no restart while latched", int'(restart_req), 0);
      cmp_on = 1'b0;
      rst_n = 1'b0;
      step(1);
      chk("R8", "reset leaves fail-safe", int'(failsafe_req), 0);
      rst_n = 1'b1;
      step(2);

      done = 1'b1;
      summary();
   end

endmodule